// File: doc/BRIEF.md
# Pulse-Swallow Feedback and Reference Divider

This block produces the two comparison strobes of a frequency synthesizer. One path divides an input tick stream by a programmable total P*N+A. It does this with a dual-modulus prescaler model that divides by P+1 or by P, steered by a swallow counter and a main counter. The other path divides an oscillator tick stream by a programmable ratio R. Both paths run in one clock domain. Each input stream arrives as a per-clock enable (`fin_en`, `osc_en`), and every enabled clock counts as one input period.

Each path latches its ratio settings only at the edge that closes a division cycle, so a cycle already in progress always runs to completion with the ratio it started with. A power-save input holds both paths in their loaded start state. A status flag reports when the swallow count in use is not below the main count.

Top module: `swallow_divider`

## Requirements
- R1: With `mod_small`=1 the prescaler modulus is 32, and consecutive `fp_pulse` strobes are P*N+A enabled `fin_en` clocks apart (N from `cfg_n`, A from `cfg_a`, A < N), including A=127.
- R2: With `mod_small`=0 the prescaler modulus is 64, and the strobe spacing is 64*N+A enabled clocks.
- R3: With A=0 the feedback strobe spacing is exactly P*N.
- R4: `fp_pulse` and `fr_pulse` are each high for exactly one clock per completed division cycle.
- R5: Consecutive `fr_pulse` strobes are R enabled `osc_en` clocks apart (R from `cfg_r`, 5 to 16383), and the reference path does not advance while `osc_en` is low.
- R6: A change to `cfg_n`, `cfg_a`, `mod_small` or `cfg_r` in the middle of a cycle does not alter that cycle. The new values govern the cycle that starts after the next strobe of that path.
- R7: `cfg_bad` is high while the feedback settings in use have A >= N and low otherwise. It changes only in the clock where `fp_pulse` rises, or under reset or power save. With A >= N the divider keeps running with a spacing of N*(P+1).
- R8: While `ps_n` is low, no strobe is produced and both paths stay at their start state. After `ps_n` rises, the first `fp_pulse` follows P*N+A enabled clocks and the first `fr_pulse` follows R enabled clocks.
- R9: The feedback path advances only on clocks where `fin_en` is high. With `fin_en` high on every other clock, the strobe spacing doubles.
- R10: While `rst_n` is low, both strobes are low and the settings on the inputs are loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for both paths |
| rst_n | input | 1 | Synchronous active-low reset |
| ps_n | input | 1 | Low: power save, both paths held at start |
| fin_en | input | 1 | One feedback input period per high clock |
| osc_en | input | 1 | One oscillator period per high clock |
| mod_small | input | 1 | 1: modulus 32/33, 0: modulus 64/65 |
| cfg_a | input | 7 | Swallow count A |
| cfg_n | input | 11 | Main count N |
| cfg_r | input | 14 | Reference ratio R |
| fp_pulse | output | 1 | Feedback comparison strobe |
| fr_pulse | output | 1 | Reference comparison strobe |
| cfg_bad | output | 1 | Feedback settings in use have A >= N |

## Verification
The bench changes settings in the middle of a cycle and measures both the remainder of that cycle and the one after it. A divider that reloaded immediately would give a shortened or stretched gap at that point. It runs A=0, A=127 and A equal to or above N. A design that swapped the two moduli, mishandled an exhausted swallow count or wrapped the swallow counter would give a spacing off by N or by a multiple of P. Gated input enables and a power-save release are measured to the exact clock. These catch counters that advance on idle clocks or do not restart from the loaded value.

// File: rtl/swallow_divider_pkg.sv
// Shared definitions for the pulse-swallow divider.
package swallow_divider_pkg;
    // Prescaler base modulus selection.
    typedef enum logic {
        PRE_LARGE = 1'b0,
        PRE_SMALL = 1'b1
    } pre_sel_e;
endpackage

// File: rtl/swallow_prescaler.sv
// Dual-modulus prescaler model: counts enabled ticks up to the modulus
// presented on its input and flags the tick that completes a period.
// Assumes the modulus is at least 2 and changes only at period ends.
module swallow_prescaler #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          tick,
    input  logic [CW-1:0] modulus,
    output logic          done
);
    logic [CW-1:0] cnt;

    // Completion is the enabled tick that lands on the last count.
    assign done = tick && (cnt == modulus - CW'(1));

    // Count enabled ticks, restarting at each completed period.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            cnt <= '0;
        end else if (done) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/swallow_feedback.sv
// Feedback path: swallow and main counters steer the prescaler so that
// one cycle spans P*N+A ticks. Settings are adopted at cycle start only.
// Assumes N >= 1; NW > AW so the validity compare zero-extends A.
module swallow_feedback
    import swallow_divider_pkg::*;
#(
    parameter int AW      = 7,
    parameter int NW      = 11,
    parameter int P_SMALL = 32,
    parameter int P_LARGE = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ps_n,
    input  logic          fin_en,
    input  logic          mod_small,
    input  logic [AW-1:0] cfg_a,
    input  logic [NW-1:0] cfg_n,
    output logic          fp_pulse,
    output logic          cfg_bad
);
    localparam int PW = $clog2(P_LARGE + 2);

    pre_sel_e      sel_act;
    logic [AW-1:0] a_cnt;
    logic [NW-1:0] n_cnt;
    logic [PW-1:0] modulus;
    logic          pre_done;
    logic          new_bad;

    // Divide by P+1 while swallow count remains, else by P.
    always_comb begin
        modulus = (sel_act == PRE_SMALL) ? PW'(P_SMALL) : PW'(P_LARGE);
        if (a_cnt != '0) modulus = modulus + PW'(1);
    end

    // Validity of the incoming settings, zero-extending A.
    assign new_bad = ({{(NW-AW){1'b0}}, cfg_a} >= cfg_n);

    swallow_prescaler #(.CW(PW)) i_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (!ps_n),
        .tick    (fin_en),
        .modulus (modulus),
        .done    (pre_done)
    );

    // Step the counters per prescaler period; reload and strobe at cycle end.
    always_ff @(posedge clk) begin
        if (!rst_n || !ps_n) begin
            a_cnt    <= cfg_a;
            n_cnt    <= cfg_n;
            sel_act  <= pre_sel_e'(mod_small);
            cfg_bad  <= new_bad;
            fp_pulse <= 1'b0;
        end else begin
            fp_pulse <= 1'b0;
            if (pre_done) begin
                if (n_cnt == NW'(1)) begin
                    a_cnt    <= cfg_a;
                    n_cnt    <= cfg_n;
                    sel_act  <= pre_sel_e'(mod_small);
                    cfg_bad  <= new_bad;
                    fp_pulse <= 1'b1;
                end else begin
                    n_cnt <= n_cnt - NW'(1);
                    if (a_cnt != '0) a_cnt <= a_cnt - AW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/swallow_refdiv.sv
// Reference path: divides enabled oscillator ticks by R, strobing once
// per cycle and adopting a new R only when a cycle completes.
// Assumes R >= 2.
module swallow_refdiv #(
    parameter int RW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ps_n,
    input  logic          osc_en,
    input  logic [RW-1:0] cfg_r,
    output logic          fr_pulse
);
    logic [RW-1:0] r_cnt;

    // Count down enabled ticks; reload from the setting at cycle end.
    always_ff @(posedge clk) begin
        if (!rst_n || !ps_n) begin
            r_cnt    <= cfg_r;
            fr_pulse <= 1'b0;
        end else begin
            fr_pulse <= 1'b0;
            if (osc_en) begin
                if (r_cnt == RW'(1)) begin
                    r_cnt    <= cfg_r;
                    fr_pulse <= 1'b1;
                end else begin
                    r_cnt <= r_cnt - RW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/swallow_divider.sv
// Top level: feedback divider (P*N+A) and reference divider (R) sharing
// one clock, each input stream given as a per-clock enable.
module swallow_divider #(
    parameter int AW      = 7,
    parameter int NW      = 11,
    parameter int RW      = 14,
    parameter int P_SMALL = 32,
    parameter int P_LARGE = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ps_n,
    input  logic          fin_en,
    input  logic          osc_en,
    input  logic          mod_small,
    input  logic [AW-1:0] cfg_a,
    input  logic [NW-1:0] cfg_n,
    input  logic [RW-1:0] cfg_r,
    output logic          fp_pulse,
    output logic          fr_pulse,
    output logic          cfg_bad
);
    swallow_feedback #(
        .AW(AW), .NW(NW), .P_SMALL(P_SMALL), .P_LARGE(P_LARGE)
    ) i_fb (
        .clk       (clk),
        .rst_n     (rst_n),
        .ps_n      (ps_n),
        .fin_en    (fin_en),
        .mod_small (mod_small),
        .cfg_a     (cfg_a),
        .cfg_n     (cfg_n),
        .fp_pulse  (fp_pulse),
        .cfg_bad   (cfg_bad)
    );

    swallow_refdiv #(.RW(RW)) i_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .ps_n     (ps_n),
        .osc_en   (osc_en),
        .cfg_r    (cfg_r),
        .fr_pulse (fr_pulse)
    );
endmodule

// File: rtl/swallow_divider_chk.sv
// Port-level temporal checks on the divider, attached through bind.
module swallow_divider_chk (
    input logic clk,
    input logic rst_n,
    input logic ps_n,
    input logic fin_en,
    input logic osc_en,
    input logic fp_pulse,
    input logic fr_pulse,
    input logic cfg_bad
);
    assert_fp_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fp_pulse |=> !fp_pulse);

    assert_fr_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fr_pulse |=> !fr_pulse);

    assert_ps_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ps_n |=> (!fp_pulse && !fr_pulse));

    assert_fin_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fin_en |=> !fp_pulse);

    assert_osc_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |=> !fr_pulse);

    assert_flag_at_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_n && $past(ps_n) && $past(rst_n) && !fp_pulse) |-> $stable(cfg_bad));
endmodule

bind swallow_divider swallow_divider_chk i_chk (.*);

// File: tb/test_swallow_divider.sv
// Directed bench: one task per scenario, gaps counted in clocks.
module test_swallow_divider;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ps_n = 1'b1;
    logic        fin_en = 1'b1;
    logic        osc_en = 1'b1;
    logic        mod_small = 1'b1;
    logic [6:0]  cfg_a = 7'd2;
    logic [10:0] cfg_n = 11'd5;
    logic [13:0] cfg_r = 14'd5;
    logic        fp_pulse, fr_pulse, cfg_bad;

    int checks = 0;
    int bad = 0;
    bit fin_gate = 1'b0;
    int osc_div = 1;
    int osc_ph = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    swallow_divider i_swallow_divider (.*);

    // Enable stream generators, updated away from the active edge.
    always @(negedge clk) begin
        fin_en <= fin_gate ? ~fin_en : 1'b1;
        osc_ph = (osc_ph + 1 >= osc_div) ? 0 : osc_ph + 1;
        osc_en <= (osc_ph == 0);
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_fp(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!fp_pulse && n < LIMIT);
    endtask

    task automatic wait_fr(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!fr_pulse && n < LIMIT);
    endtask

    task automatic set_fb(input bit s, input int a, input int n);
        mod_small = s; cfg_a = 7'(a); cfg_n = 11'(n);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R10 fp in reset", int'(fp_pulse), 0);
        check("R10 fr in reset", int'(fr_pulse), 0);
        check("R10 flag in reset", int'(cfg_bad), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_small;
        int n;
        wait_fp(n); check("R1 first gap 32*5+2", n, 162);
        @(negedge clk); check("R4 fp one clock", int'(fp_pulse), 0);
        wait_fp(n); check("R1 gap 32*5+2", n + 1, 162);
        set_fb(1, 127, 200);
        wait_fp(n); wait_fp(n); check("R1 gap 32*200+127", n, 6527);
    endtask

    task automatic t_large;
        int n;
        set_fb(0, 3, 6);
        wait_fp(n); wait_fp(n); check("R2 gap 64*6+3", n, 387);
    endtask

    task automatic t_zero_a;
        int n;
        set_fb(1, 0, 7);
        wait_fp(n); wait_fp(n); check("R3 gap 32*7", n, 224);
    endtask

    task automatic t_boundary;
        int n;
        repeat (20) @(negedge clk);
        set_fb(1, 2, 5);
        wait_fp(n); check("R6 old ratio kept", n + 20, 224);
        wait_fp(n); check("R6 new ratio after edge", n, 162);
    endtask

    task automatic t_invalid;
        int n;
        repeat (10) @(negedge clk);
        set_fb(1, 7, 5);
        @(negedge clk); check("R7 flag waits for edge", int'(cfg_bad), 0);
        wait_fp(n); check("R7 flag at edge", int'(cfg_bad), 1);
        wait_fp(n); check("R7 gap 5*33", n, 165);
        set_fb(1, 5, 5);
        wait_fp(n); wait_fp(n);
        check("R7 A equal N gap", n, 165);
        check("R7 A equal N flag", int'(cfg_bad), 1);
        set_fb(1, 2, 5);
        wait_fp(n); check("R7 flag clears", int'(cfg_bad), 0);
    endtask

    task automatic t_gate;
        int n;
        fin_gate = 1'b1;
        wait_fp(n); wait_fp(n); check("R9 half-rate gap", n, 324);
        fin_gate = 1'b0;
        wait_fp(n);
    endtask

    task automatic t_ref;
        int n;
        wait_fr(n); wait_fr(n); check("R5 gap R=5", n, 5);
        @(negedge clk); check("R4 fr one clock", int'(fr_pulse), 0);
        cfg_r = 14'd300;
        wait_fr(n); check("R6 ref old ratio kept", n + 1, 5);
        wait_fr(n); check("R5 gap R=300", n, 300);
        cfg_r = 14'd7; osc_div = 3;
        wait_fr(n); wait_fr(n); check("R5 gated gap 3*7", n, 21);
        osc_div = 1;
        wait_fr(n);
    endtask

    task automatic t_power;
        int fp_cnt = 0, fr_cnt = 0, first_fp = 0, first_fr = 0;
        cfg_r = 14'd40;
        set_fb(1, 2, 5);
        ps_n = 1'b0;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (fp_pulse) fp_cnt++;
            if (fr_pulse) fr_cnt++;
        end
        check("R8 no fp in power save", fp_cnt, 0);
        check("R8 no fr in power save", fr_cnt, 0);
        ps_n = 1'b1;
        for (int i = 1; i <= 400; i++) begin
            @(negedge clk);
            if (fp_pulse && first_fp == 0) first_fp = i;
            if (fr_pulse && first_fr == 0) first_fr = i;
        end
        check("R8 first fp after release", first_fp, 162);
        check("R8 first fr after release", first_fr, 40);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_small();
        t_large();
        t_zero_a();
        t_boundary();
        t_invalid();
        t_gate();
        t_ref();
        t_power();
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        checks++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule